// File: doc/BRIEF.md
# Dual-Mode Interrupt Router and Priority Encoder

This block takes six level-sensitive interrupt requests and turns them into one prioritised request toward the processor. The sources are two timer/I/O controllers, a network controller, a serial controller, a sound controller and a non-maskable source. Each source maps to one bit of an 8-bit pending register. A routing-mode pin picks the mapping. The highest pending bit sets a registered 3-bit priority level and an autovector number.

In classic routing, the network and sound requests skip the encoder. The network request goes straight to a slot-interrupt side output. The sound request goes inverted to a second side output, so the consumer sees a falling edge when sound asserts. A one-cycle NMI pulse request holds the NMI source active for a programmable time, counted in clock cycles.

Pending bits change only when a request changes level, and the bit touched is the one given by the mapping in force at that time. A mode switch therefore leaves bits already set where they are.

Top module: `irq_router_top`

## Requirements
- R1: With the registered mode high (classic), controller 1 drives pending bit 0, controller 2 bit 1, serial bit 3 and NMI bit 6.
- R2: In classic mode, each level change of the network request is copied to `slot_irq`, and the network request touches no pending bit.
- R3: In classic mode, each level change of the sound request drives `snd_irq_n` to the inverse of the request, and the sound request touches no pending bit.
- R4: With the registered mode low (alternate), controller 1 drives bit 5, controller 2 bit 1, network bit 2, serial bit 3, sound bit 4 and NMI bit 6.
- R5: A pending bit is set when its request rises and cleared when it falls. Nothing is latched beyond the request level.
- R6: If the highest set pending bit has index i, then `ipl` = i+1 and `vec` = i+25. Bit 7 is never mapped.
- R7: With no pending bit set, `ipl` = 0 and `vec` = 0.
- R8: A one-cycle `nmi_pulse` keeps the NMI source active for CLK_KHZ*HOLD_MS cycles. A new pulse during a hold reloads the full count.
- R9: Reset clears the pending register, forces the registered mode low, cancels any NMI hold, and sets `slot_irq` to 0 and `snd_irq_n` to 1. The mode pin is sampled into the registered mode one edge after reset is released.
- R10: A mode change leaves pending bits unchanged. A later request change updates the bit chosen by the new mapping.
- R11: `ipl`, `vec` and the side outputs change on the first clock edge that samples a request change, and not before.
- R12: In alternate mode, `slot_irq` and `snd_irq_n` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_classic | input | 1 | Routing mode pin: 1 selects classic, 0 selects alternate |
| req_tio1 | input | 1 | Timer/I/O controller 1 request |
| req_tio2 | input | 1 | Timer/I/O controller 2 request |
| req_net | input | 1 | Network controller request |
| req_ser | input | 1 | Serial controller request |
| req_snd | input | 1 | Sound controller request |
| req_nmi | input | 1 | Non-maskable request, level |
| nmi_pulse | input | 1 | One-cycle request to start or reload an NMI hold |
| ipl | output | 3 | Registered priority level |
| vec | output | 8 | Registered autovector number |
| slot_irq | output | 1 | Classic-mode copy of the network request |
| snd_irq_n | output | 1 | Classic-mode inverted sound request |

## Verification
The bench builds the block with CLK_KHZ=1 and HOLD_MS=20, so an NMI hold lasts 20 cycles instead of millions. This lets the bench run the whole hold, reload it partway through, and cut it short with a reset. With the small hold, random pulses can also land in the middle of random request traffic in both routing modes. The stale-bit case after a mode switch is checked, and so is the mode pin being held high through reset.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NSRC = 6;
  localparam int NPEND = 8;
  localparam int VEC_BASE = 25;

  typedef enum int {
    SRC_TIO1 = 0, SRC_TIO2 = 1, SRC_NET = 2, SRC_SER = 3, SRC_SND = 4, SRC_NMI = 5
  } src_e;

  // pending-bit index for source s under the given routing mode
  function automatic logic [2:0] route_bit(input int s, input logic classic);
    logic [2:0] b;
    case (s)
      SRC_TIO1: b = classic ? 3'd0 : 3'd5;
      SRC_TIO2: b = 3'd1;
      SRC_NET:  b = 3'd2;
      SRC_SER:  b = 3'd3;
      SRC_SND:  b = 3'd4;
      default:  b = 3'd6;
    endcase
    return b;
  endfunction

  // true when the source skips the encoder and feeds a side output
  function automatic logic diverted(input int s, input logic classic);
    return classic && (s == SRC_NET || s == SRC_SND);
  endfunction

  function automatic logic [2:0] encode_level(input logic [NPEND-1:0] p);
    logic [2:0] l;
    l = 3'd0;
    for (int i = 0; i < NPEND - 1; i++)
      if (p[i]) l = 3'(i + 1);
    return l;
  endfunction

  function automatic logic [7:0] encode_vector(input logic [2:0] l);
    return (l == 3'd0) ? 8'd0 : 8'(VEC_BASE - 1 + int'(l));
  endfunction
endpackage

// File: rtl/irq_nmi_stretch.sv
module irq_nmi_stretch #(
  parameter int unsigned HOLD = 20,
  parameter int CW = $clog2(HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse,
  output logic          active,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (pulse)     cnt <= CW'(HOLD);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
  import irq_router_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             classic,
  input  logic [NSRC-1:0]  req,
  output logic [NPEND-1:0] pend,
  output logic [NPEND-1:0] pend_nxt,
  output logic [NSRC-1:0]  req_chg,
  output logic             slot_irq,
  output logic             snd_irq_n
);
  logic [NSRC-1:0] req_prev;
  logic            slot_nxt, sndn_nxt;

  assign req_chg = req ^ req_prev;

  always_comb begin
    pend_nxt = pend;
    slot_nxt = slot_irq;
    sndn_nxt = snd_irq_n;
    for (int s = 0; s < NSRC; s++) begin
      if (req_chg[s]) begin
        if (diverted(s, classic)) begin
          if (s == SRC_NET) slot_nxt = req[s];
          else              sndn_nxt = ~req[s];
        end else begin
          pend_nxt[route_bit(s, classic)] = req[s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_prev  <= '0;
      pend      <= '0;
      slot_irq  <= 1'b0;
      snd_irq_n <= 1'b1;
    end else begin
      req_prev  <= req;
      pend      <= pend_nxt;
      slot_irq  <= slot_nxt;
      snd_irq_n <= sndn_nxt;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_router_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPEND-1:0] pend_nxt,
  output logic [2:0]       ipl,
  output logic [7:0]       vec
);
  logic [2:0] lvl_nxt;
  assign lvl_nxt = encode_level(pend_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipl <= 3'd0;
      vec <= 8'd0;
    end else begin
      ipl <= lvl_nxt;
      vec <= encode_vector(lvl_nxt);
    end
  end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned HOLD_MS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_classic,
  input  logic       req_tio1,
  input  logic       req_tio2,
  input  logic       req_net,
  input  logic       req_ser,
  input  logic       req_snd,
  input  logic       req_nmi,
  input  logic       nmi_pulse,
  output logic [2:0] ipl,
  output logic [7:0] vec,
  output logic       slot_irq,
  output logic       snd_irq_n
);
  localparam int unsigned HOLD_CYCLES = CLK_KHZ * HOLD_MS;
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic             mode_q;
  logic             nmi_hold;
  logic [CNT_W-1:0] hold_cnt;
  logic [31:0]      hold_cnt_ext;
  logic [NSRC-1:0]  req_vec;
  logic [NSRC-1:0]  req_chg;
  logic [NPEND-1:0] pend, pend_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_classic;
  end

  irq_nmi_stretch #(.HOLD(HOLD_CYCLES), .CW(CNT_W)) u_nmi (
    .clk(clk), .rst_n(rst_n), .pulse(nmi_pulse), .active(nmi_hold), .cnt(hold_cnt)
  );

  assign hold_cnt_ext = 32'(hold_cnt);

  assign req_vec = {req_nmi | nmi_hold, req_snd, req_ser, req_net, req_tio2, req_tio1};

  irq_src_router u_route (
    .clk(clk), .rst_n(rst_n), .classic(mode_q), .req(req_vec),
    .pend(pend), .pend_nxt(pend_nxt), .req_chg(req_chg),
    .slot_irq(slot_irq), .snd_irq_n(snd_irq_n)
  );

  irq_prio_enc u_enc (
    .clk(clk), .rst_n(rst_n), .pend_nxt(pend_nxt), .ipl(ipl), .vec(vec)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned HOLD_MS = 100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_q,
  input logic        nmi_pulse,
  input logic [31:0] hold_cnt,
  input logic [7:0]  pend,
  input logic [2:0]  ipl,
  input logic [7:0]  vec,
  input logic        slot_irq,
  input logic        snd_irq_n
);
  localparam int unsigned HOLD_CYCLES = CLK_KHZ * HOLD_MS;

  assert_vec_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl != 3'd0) |-> (vec == 8'(24 + int'(ipl))));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == 8'd0) |-> (ipl == 3'd0 && vec == 8'd0));

  assert_hold_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |=> (hold_cnt == HOLD_CYCLES));

  assert_hold_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt != 0 && !nmi_pulse) |=> (hold_cnt == $past(hold_cnt) - 1));

  assert_side_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |=> ($stable(slot_irq) && $stable(snd_irq_n)));

  assert_no_bit7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[7]);
endmodule

bind irq_router_top irq_router_chk #(.CLK_KHZ(CLK_KHZ), .HOLD_MS(HOLD_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .nmi_pulse(nmi_pulse),
  .hold_cnt(hold_cnt_ext), .pend(pend), .ipl(ipl), .vec(vec),
  .slot_irq(slot_irq), .snd_irq_n(snd_irq_n)
);

// File: tb/sim_irq_router_top.sv
module sim_irq_router_top;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_classic = 1'b0;
  logic [5:0] rq = '0;
  logic nmi_pulse = 1'b0;
  logic [2:0] ipl;
  logic [7:0] vec;
  logic slot_irq, snd_irq_n;

  int total = 0, bad = 0;

  // reference state
  logic [5:0] m_prev;
  logic [7:0] m_pend;
  logic m_mode, m_slot, m_sndn;
  int m_cnt;

  always #5 clk = ~clk;

  irq_router_top #(.CLK_KHZ(1), .HOLD_MS(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_classic(mode_classic),
    .req_tio1(rq[0]), .req_tio2(rq[1]), .req_net(rq[2]), .req_ser(rq[3]),
    .req_snd(rq[4]), .req_nmi(rq[5]), .nmi_pulse(nmi_pulse),
    .ipl(ipl), .vec(vec), .slot_irq(slot_irq), .snd_irq_n(snd_irq_n)
  );

  function automatic int bit_for(int s, logic classic);
    int cmap[6] = '{0, 1, -1, 3, -1, 6};
    int amap[6] = '{5, 1, 2, 3, 4, 6};
    return classic ? cmap[s] : amap[s];
  endfunction

  function automatic int top_index(logic [7:0] p);
    for (int i = 7; i >= 0; i--) if (p[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    m_prev = '0; m_pend = '0; m_mode = 1'b0; m_slot = 1'b0; m_sndn = 1'b1; m_cnt = 0;
  endtask

  // one clock edge of the reference, using the values held before the edge
  task automatic model_edge();
    logic [5:0] eff;
    eff = rq;
    eff[5] = rq[5] | (m_cnt != 0);
    for (int s = 0; s < 6; s++) begin
      if (eff[s] != m_prev[s]) begin
        if (m_mode && s == 2)      m_slot = eff[s];
        else if (m_mode && s == 4) m_sndn = ~eff[s];
        else                       m_pend[bit_for(s, m_mode)] = eff[s];
      end
    end
    m_prev = eff;
    if (nmi_pulse) m_cnt = HOLD;
    else if (m_cnt > 0) m_cnt--;
    m_mode = mode_classic;
  endtask

  task automatic check(string tag);
    int t;
    logic [2:0] el;
    logic [7:0] ev;
    t = top_index(m_pend);
    el = (t < 0) ? 3'd0 : 3'(t + 1);
    ev = (t < 0) ? 8'd0 : 8'(t + 25);
    total++;
    if (ipl !== el || vec !== ev || slot_irq !== m_slot || snd_irq_n !== m_sndn) begin
      bad++;
      $display("FAIL %s: ipl=%0d vec=%0d slot=%b sndn=%b expected ipl=%0d vec=%0d slot=%b sndn=%b",
               tag, ipl, vec, slot_irq, snd_irq_n, el, ev, m_slot, m_sndn);
    end
  endtask

  task automatic step(logic [5:0] v, logic pul, string tag);
    rq = v; nmi_pulse = pul;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    nmi_pulse = 1'b0;
    check(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  task automatic expect_ipl(logic [2:0] e, string tag);
    total++;
    if (ipl !== e) begin
      bad++;
      $display("FAIL %s: ipl=%0d expected %0d", tag, ipl, e);
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    @(negedge clk);
    do_reset();
    check("R9 reset state");
    step(6'b0, 0, "R7 idle");

    // alternate mapping, one source at a time (R4, R6)
    for (int s = 0; s < 6; s++) begin
      step(6'(1 << s), 0, "R4 alt single source");
      step(6'b0, 0, "R5 alt release");
    end
    step(6'b100001, 0, "R6 nmi above tio1");
    step(6'b000001, 0, "R5 nmi drop leaves tio1");
    step(6'b0, 0, "R7 all clear");

    // R11: a change is not visible before the sampling edge
    rq = 6'b001000;
    #2;
    expect_ipl(3'd0, "R11 no early update");
    step(6'b001000, 0, "R11 one-edge update");
    step(6'b0, 0, "R11 release");

    // classic mapping
    mode_classic = 1'b1;
    step(6'b0, 0, "R1 mode settle");
    for (int s = 0; s < 6; s++) begin
      step(6'(1 << s), 0, "R1 classic single source");
      step(6'b0, 0, "R1 classic release");
    end
    step(6'b000100, 0, "R2 net to slot");
    step(6'b010100, 0, "R3 sound inverted");
    step(6'b011101, 0, "R2 R3 with encoded bits");
    step(6'b0, 0, "R2 R3 release");

    // R10: stale bit after a mode switch
    mode_classic = 1'b0;
    step(6'b0, 0, "R10 to alt");
    step(6'b000001, 0, "R10 tio1 at bit 5");
    mode_classic = 1'b1;
    step(6'b000001, 0, "R10 to classic");
    step(6'b0, 0, "R10 stale bit 5 stays");
    mode_classic = 1'b0;
    step(6'b0, 0, "R10 back to alt");
    step(6'b000001, 0, "R10 re-raise");
    step(6'b0, 0, "R10 clear bit 5");
    step(6'b010100, 0, "R12 alt leaves side outputs");

    // R8: NMI stretch and reload
    step(6'b0, 1, "R8 pulse");
    for (int k = 0; k < HOLD + 4; k++) begin
      step(6'b0, (k == 10), "R8 hold window");
    end
    for (int k = 0; k < 12; k++) step(6'b0, 0, "R8 hold expiry");

    // R9: reset during a hold, mode pin high through reset
    step(6'b0, 1, "R9 pulse before reset");
    step(6'b0, 0, "R9 hold running");
    mode_classic = 1'b1;
    rq = 6'b000001;
    do_reset();
    check("R9 reset clears");
    step(6'b000001, 0, "R9 first edge uses alt mapping");
    for (int k = 0; k < HOLD + 2; k++) step(6'b000001, 0, "R9 hold cancelled");
    step(6'b0, 0, "R9 release");

    // random traffic in both modes
    for (int ph = 0; ph < 4; ph++) begin
      mode_classic = ph[0];
      step(rq, 0, "R5 mode settle");
      for (int k = 0; k < 1500; k++) begin
        logic [5:0] v;
        v = 6'($urandom);
        step(v, ($urandom % 97) == 0, "R5 random");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule